// File: doc/BRIEF.md
# Dual Wakeup Pin Qualifier

This block turns two raw wakeup pins into a clean wakeup request for the always-on power controller. It runs entirely in the slow 32 kHz domain. Each pin is first passed through a two-flop synchronizer. It then goes through an optional stability filter and is decoded according to a programmable active type: a level, or a single-cycle edge pulse. The two qualified pins are merged with either OR or AND logic. Each pin can be masked off on its own.

The merged pin event joins the RTC and button wakeup requests. These events are gated by the current power state, and only the OFF state acts on them. An event that arrives while in the RTC state is either dropped or parked until OFF is entered, depending on a latch control. Every delivered event sets a bit in a sticky source register. A hardware-reset event input also sets its own bit there. All bits stay set until an explicit clear.

The filter window is one slow-clock period times 2^interval times (count + 2). A fast glitch capture option on pin 0 bypasses that pin's filter.

Top module: `wkq_wakeup_qual`

## Requirements
- R1: Active type per pin, 2 bits: 0 = high level, 1 = low level, 2 = rising edge, 3 = falling edge. Level types hold `wake_req_o` high while the level persists in OFF. Edge types give a one-cycle pulse.
- R2: With the filter applied to a transition, it is accepted only after the synchronized pin has differed from the filtered value for (count + 2) << interval consecutive cycles. When a pin change is first sampled at edge E0, `wake_req_o` responds after edge E(2 + that length).
- R3: A pin excursion shorter than the filter length is rejected and produces no wakeup. An excursion of exactly the filter length is accepted.
- R4: The filter edge set per pin, 2 bits: 0 = rising only, 1 = falling only, 2 or 3 = both. A transition outside the set passes unfiltered, and `wake_req_o` responds after edge E3.
- R5: Combine control 0 raises a pin event when any enabled pin is active. Combine control 1 needs every pin enabled and active. A disabled pin counts as inactive in both modes.
- R6: Wake enable mask: bit 0 = pin 0, bit 1 = pin 1, bit 2 = RTC, bit 3 = button. A masked source produces no request and sets no source bit.
- R7: Power state, 2 bits: 0 = RUN, 1 = RTC, 2 = OFF, 3 = treated as RUN. Only OFF delivers events. A delivered event raises `wake_req_o` one cycle later.
- R8: An event in RTC is not delivered there. With latch control 0 it is discarded. With latch control 1 it is held per source and delivered on the first clock edge at which the state is OFF.
- R9: Source register bits: 0 = button, 1 = RTC, 2 = pin, 3 = hardware reset. Bits are set on delivery (bit 3 on the reset event in any state) and stay set until `src_clr_i`. A set in the same cycle as a clear wins.
- R10: A nonzero pin 0 glitch-capture selection bypasses pin 0's filter. Pin 1 keeps its filter.
- R11: After reset, `wake_req_o` is 0, the source register is 0 and no event is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32 kHz domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 2 | Raw wakeup pins |
| wake_en_i | input | 4 | Source enable mask |
| act_type_i | input | 4 | Active type, 2 bits per pin |
| flt_en_i | input | 2 | Filter enable per pin |
| flt_edge_i | input | 4 | Filter edge set, 2 bits per pin |
| flt_intv_i | input | 2*INTV_W | Filter sample interval exponent per pin |
| flt_cnt_i | input | 2*CNT_W | Filter count per pin |
| glitch_sel_i | input | 2 | Pin 0 fast capture edge selection (rise, fall) |
| combine_and_i | input | 1 | 0 = OR, 1 = AND of pins |
| rtc_latch_i | input | 1 | Hold RTC-state events until OFF |
| pwr_state_i | input | 2 | Current power state |
| rtc_wake_i | input | 1 | RTC wakeup request |
| btn_wake_i | input | 1 | Button wakeup request |
| hw_rst_evt_i | input | 1 | Hardware reset event |
| src_clr_i | input | 1 | Clear the source register |
| wake_req_o | output | 1 | Wakeup request |
| wake_src_o | output | 4 | Sticky wakeup source register |

## Verification
The bench builds the block with the default widths, INTV_W = 4 and CNT_W = 4. It draws intervals from 0 to 3 and counts from the full 0 to 15 range, so every filter window stays within 136 cycles. This covers the shortest window (2 cycles), the longest count, and the exact one-cycle accept/reject boundary of the restart rule. It also reaches both filter directions, the glitch bypass, and the RTC latch and discard paths.

// File: rtl/wkq_pkg.sv
package wkq_pkg;
  localparam int PIN_CNT     = 2;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {ACT_HIGH = 2'd0, ACT_LOW = 2'd1, ACT_RISE = 2'd2, ACT_FALL = 2'd3} act_type_e;
  typedef enum logic [1:0] {FLT_RISE = 2'd0, FLT_FALL = 2'd1, FLT_BOTH = 2'd2, FLT_BOTH_ALT = 2'd3} flt_edge_e;
  typedef enum logic [1:0] {PS_RUN = 2'd0, PS_RTC = 2'd1, PS_OFF = 2'd2, PS_RSVD = 2'd3} pwr_state_e;

  localparam int SRC_BTN = 0;
  localparam int SRC_RTC = 1;
  localparam int SRC_PIN = 2;
  localparam int SRC_HWR = 3;
  localparam int SRC_W   = 4;
  localparam int EVT_W   = 3;

  localparam int EN_RTC = PIN_CNT;
  localparam int EN_BTN = PIN_CNT + 1;
  localparam int EN_W   = PIN_CNT + 2;
endpackage

// File: rtl/wkq_sync.sv
module wkq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/wkq_edge_filter.sv
module wkq_edge_filter import wkq_pkg::*; #(
  parameter int INTV_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_i,
  input  logic              flt_en_i,
  input  logic [1:0]        edge_sel_i,
  input  logic [INTV_W-1:0] intv_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              flt_o
);
  localparam int LIM_W = CNT_W + 1 + (1 << INTV_W) - 1;

  logic [CNT_W:0]     span;
  logic [LIM_W-1:0]   lim, cnt_q;
  logic               flt_q, rise, fall, use_flt, last;
  flt_edge_e          sel;

  assign sel  = flt_edge_e'(edge_sel_i);
  assign span = {1'b0, cnt_i} + (CNT_W+1)'(2);
  assign lim  = {{(LIM_W-CNT_W-1){1'b0}}, span} << intv_i;
  assign last = (cnt_q >= lim - LIM_W'(1));

  assign rise    = smp_i & ~flt_q;
  assign fall    = ~smp_i & flt_q;
  assign use_flt = flt_en_i & ((rise & (sel != FLT_FALL)) | (fall & (sel != FLT_RISE)));

  // any return to the held value restarts the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else if (smp_i == flt_q) begin
      cnt_q <= '0;
    end else if (!use_flt || last) begin
      flt_q <= smp_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + LIM_W'(1);
    end
  end

  assign flt_o = flt_q;

  assert_hold_until_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((smp_i != flt_q) && use_flt && !last) |=> (flt_q == $past(flt_q)));

  assert_bypass_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((smp_i != flt_q) && !use_flt) |=> (flt_q == $past(smp_i)));
endmodule

// File: rtl/wkq_pin_chan.sv
module wkq_pin_chan import wkq_pkg::*; #(
  parameter int INTV_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              flt_en_i,
  input  logic [1:0]        edge_sel_i,
  input  logic [INTV_W-1:0] intv_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        type_i,
  output logic              act_o
);
  logic smp, lvl, lvl_prev;

  wkq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (smp)
  );

  wkq_edge_filter #(.INTV_W(INTV_W), .CNT_W(CNT_W)) u_flt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_i     (smp),
    .flt_en_i  (flt_en_i),
    .edge_sel_i(edge_sel_i),
    .intv_i    (intv_i),
    .cnt_i     (cnt_i),
    .flt_o     (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_prev <= 1'b0;
    else         lvl_prev <= lvl;
  end

  always_comb begin
    unique case (act_type_e'(type_i))
      ACT_HIGH: act_o = lvl;
      ACT_LOW:  act_o = ~lvl;
      ACT_RISE: act_o = lvl & ~lvl_prev;
      ACT_FALL: act_o = ~lvl & lvl_prev;
      default:  act_o = 1'b0;
    endcase
  end

  assert_edge_single_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_i[1] && act_o) |=> (!act_o || !$stable(type_i)));
endmodule

// File: rtl/wkq_wake_gate.sv
module wkq_wake_gate import wkq_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       pwr_state_i,
  input  logic             rtc_latch_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             hw_rst_evt_i,
  input  logic             src_clr_i,
  output logic             wake_req_o,
  output logic [SRC_W-1:0] wake_src_o
);
  pwr_state_e       st;
  logic [EVT_W-1:0] pend_q, pend_d, deliver;
  logic [SRC_W-1:0] src_q;
  logic             req_q;

  assign st = pwr_state_e'(pwr_state_i);

  always_comb begin
    deliver = '0;
    pend_d  = pend_q;
    unique case (st)
      PS_OFF: begin
        deliver = evt_i | pend_q;
        pend_d  = '0;
      end
      PS_RTC:  if (rtc_latch_i) pend_d = pend_q | evt_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      src_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      req_q  <= |deliver;
      src_q  <= (src_q & {SRC_W{~src_clr_i}}) | {hw_rst_evt_i, deliver};
    end
  end

  assign wake_req_o = req_q;
  assign wake_src_o = src_q;

  assert_req_only_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> ($past(pwr_state_i) == PS_OFF));

  assert_src_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_clr_i |=> ((wake_src_o & $past(wake_src_o)) == $past(wake_src_o)));

  assert_req_marks_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> (|wake_src_o[EVT_W-1:0]));

  assert_pend_flush_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == PS_OFF) |=> (pend_q == '0));

  assert_no_pend_unlatched_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rtc_latch_i && pend_q == '0) |=> (pend_q == '0));
endmodule

// File: rtl/wkq_wakeup_qual.sv
module wkq_wakeup_qual import wkq_pkg::*; #(
  parameter int INTV_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [PIN_CNT-1:0]        pin_i,
  input  logic [EN_W-1:0]           wake_en_i,
  input  logic [2*PIN_CNT-1:0]      act_type_i,
  input  logic [PIN_CNT-1:0]        flt_en_i,
  input  logic [2*PIN_CNT-1:0]      flt_edge_i,
  input  logic [INTV_W*PIN_CNT-1:0] flt_intv_i,
  input  logic [CNT_W*PIN_CNT-1:0]  flt_cnt_i,
  input  logic [1:0]                glitch_sel_i,
  input  logic                      combine_and_i,
  input  logic                      rtc_latch_i,
  input  logic [1:0]                pwr_state_i,
  input  logic                      rtc_wake_i,
  input  logic                      btn_wake_i,
  input  logic                      hw_rst_evt_i,
  input  logic                      src_clr_i,
  output logic                      wake_req_o,
  output logic [SRC_W-1:0]          wake_src_o
);
  logic [PIN_CNT-1:0] act, act_m, flt_en_eff;
  logic               pin_evt;
  logic [EVT_W-1:0]   evt;

  for (genvar g = 0; g < PIN_CNT; g++) begin : g_pin
    if (g == 0) begin : g_bypass
      // fast capture on pin 0 replaces its filter
      assign flt_en_eff[g] = flt_en_i[g] & ~(|glitch_sel_i);
    end else begin : g_plain
      assign flt_en_eff[g] = flt_en_i[g];
    end

    wkq_pin_chan #(.INTV_W(INTV_W), .CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (pin_i[g]),
      .flt_en_i  (flt_en_eff[g]),
      .edge_sel_i(flt_edge_i[2*g +: 2]),
      .intv_i    (flt_intv_i[INTV_W*g +: INTV_W]),
      .cnt_i     (flt_cnt_i[CNT_W*g +: CNT_W]),
      .type_i    (act_type_i[2*g +: 2]),
      .act_o     (act[g])
    );
  end

  assign act_m   = act & wake_en_i[PIN_CNT-1:0];
  assign pin_evt = combine_and_i ? (&act_m) : (|act_m);

  assign evt[SRC_BTN] = btn_wake_i & wake_en_i[EN_BTN];
  assign evt[SRC_RTC] = rtc_wake_i & wake_en_i[EN_RTC];
  assign evt[SRC_PIN] = pin_evt;

  wkq_wake_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_state_i (pwr_state_i),
    .rtc_latch_i (rtc_latch_i),
    .evt_i       (evt),
    .hw_rst_evt_i(hw_rst_evt_i),
    .src_clr_i   (src_clr_i),
    .wake_req_o  (wake_req_o),
    .wake_src_o  (wake_src_o)
  );
endmodule

// File: tb/tb_wkq_wakeup_qual.sv
`timescale 1ns/1ps
module tb_wkq_wakeup_qual;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] pin = '0;
  logic [3:0] wake_en = '0;
  logic [3:0] act_type = '0;
  logic [1:0] flt_en = '0;
  logic [3:0] flt_edge = '0;
  logic [7:0] flt_intv = '0;
  logic [7:0] flt_cnt = '0;
  logic [1:0] glitch_sel = '0;
  logic       comb_and = 1'b0;
  logic       rtc_latch = 1'b0;
  logic [1:0] pwr_state = '0;
  logic       rtc_wake = 1'b0;
  logic       btn_wake = 1'b0;
  logic       hw_evt = 1'b0;
  logic       src_clr = 1'b0;
  logic       wake_req;
  logic [3:0] wake_src;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wkq_wakeup_qual dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .wake_en_i(wake_en),
    .act_type_i(act_type), .flt_en_i(flt_en), .flt_edge_i(flt_edge),
    .flt_intv_i(flt_intv), .flt_cnt_i(flt_cnt), .glitch_sel_i(glitch_sel),
    .combine_and_i(comb_and), .rtc_latch_i(rtc_latch), .pwr_state_i(pwr_state),
    .rtc_wake_i(rtc_wake), .btn_wake_i(btn_wake), .hw_rst_evt_i(hw_evt),
    .src_clr_i(src_clr), .wake_req_o(wake_req), .wake_src_o(wake_src)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int flt_len(input int intv, input int cnt);
    return (cnt + 2) << intv;
  endfunction

  function automatic bit exp_pins(input logic [1:0] en, input logic [1:0] lvl,
                                  input logic [1:0] low_act, input bit and_m);
    logic [1:0] a;
    for (int g = 0; g < 2; g++) a[g] = en[g] & (low_act[g] ? ~lvl[g] : lvl[g]);
    return and_m ? (&a) : (|a);
  endfunction

  task automatic quiet();
    pwr_state = 2'd0; pin = '0; flt_en = '0; glitch_sel = '0;
    rtc_wake = 0; btn_wake = 0; hw_evt = 0; rtc_latch = 0; comb_and = 0;
    step(6);
    src_clr = 1; step(1); src_clr = 0; step(1);
  endtask

  task automatic watch(input int n_hi, input int n_tail, output bit saw);
    saw = 0;
    pin[0] = 1;
    for (int k = 0; k < n_hi; k++) begin step(1); saw |= wake_req; end
    pin[0] = 0;
    for (int k = 0; k < n_tail; k++) begin step(1); saw |= wake_req; end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int L;
    bit saw;
    void'($urandom(32'd4711));
    step(3);
    rst_ni = 1;
    step(2);
    chk("R11 req after reset", 32'(wake_req), 0);
    chk("R11 src after reset", 32'(wake_src), 0);

    // R1 high level
    quiet(); wake_en = 4'b0001; act_type = 4'b0000; pwr_state = 2'd2; step(2);
    chk("R1 high idle", 32'(wake_req), 0);
    pin[0] = 1; step(3);
    chk("R1 high early", 32'(wake_req), 0);
    step(1); chk("R1 high asserted", 32'(wake_req), 1);
    step(5); chk("R1 high held", 32'(wake_req), 1);
    chk("R9 pin source", 32'(wake_src), 32'h4);

    // R1 rising edge
    quiet(); act_type = 4'b0010; pwr_state = 2'd2; step(2);
    pin[0] = 1; step(3); chk("R1 rise early", 32'(wake_req), 0);
    step(1); chk("R1 rise pulse", 32'(wake_req), 1);
    step(1); chk("R1 rise single", 32'(wake_req), 0);

    // R1 falling edge
    quiet(); act_type = 4'b0011; pin[0] = 1; step(6); pwr_state = 2'd2; step(2);
    chk("R1 fall idle", 32'(wake_req), 0);
    pin[0] = 0; step(3); chk("R1 fall early", 32'(wake_req), 0);
    step(1); chk("R1 fall pulse", 32'(wake_req), 1);
    step(1); chk("R1 fall single", 32'(wake_req), 0);

    // R1 low level
    quiet(); act_type = 4'b0001; pwr_state = 2'd2; step(1);
    chk("R1 low active", 32'(wake_req), 1);
    pin[0] = 1; step(3); chk("R1 low still", 32'(wake_req), 1);
    step(1); chk("R1 low released", 32'(wake_req), 0);

    // R2 filter length, directed extremes then random
    for (int i = 0; i < 8; i++) begin
      int iv, ct;
      quiet();
      iv = (i == 0) ? 0 : (i == 1) ? 3 : int'($urandom % 4);
      ct = (i == 0) ? 0 : (i == 1) ? 15 : int'($urandom % 16);
      act_type = 4'b0000; wake_en = 4'b0001; flt_en = 2'b01; flt_edge = 4'b0010;
      flt_intv = 8'(iv); flt_cnt = 8'(ct); pwr_state = 2'd2; step(2);
      L = flt_len(iv, ct);
      pin[0] = 1; step(2 + L);
      chk($sformatf("R2 before window iv=%0d ct=%0d", iv, ct), 32'(wake_req), 0);
      step(1);
      chk($sformatf("R2 after window iv=%0d ct=%0d", iv, ct), 32'(wake_req), 1);
    end

    // R3 restart boundary, L = 5
    quiet(); act_type = 4'b0000; wake_en = 4'b0001; flt_en = 2'b01; flt_edge = 4'b0010;
    flt_intv = 8'd0; flt_cnt = 8'd3; pwr_state = 2'd2; step(2);
    watch(4, 20, saw); chk("R3 short rejected", 32'(saw), 0);
    watch(5, 20, saw); chk("R3 exact accepted", 32'(saw), 1);

    // R4 rising-only filter, L = 16
    quiet(); act_type = 4'b0000; wake_en = 4'b0001; flt_en = 2'b01; flt_edge = 4'b0000;
    flt_intv = 8'd2; flt_cnt = 8'd2; pwr_state = 2'd2; step(2);
    pin[0] = 1; step(18); chk("R4 rise filtered early", 32'(wake_req), 0);
    step(1); chk("R4 rise filtered", 32'(wake_req), 1);
    pin[0] = 0; step(3); chk("R4 fall bypass early", 32'(wake_req), 1);
    step(1); chk("R4 fall bypass", 32'(wake_req), 0);
    // falling-only filter
    quiet(); act_type = 4'b0000; wake_en = 4'b0001; flt_en = 2'b01; flt_edge = 4'b0001;
    flt_intv = 8'd2; flt_cnt = 8'd2; pwr_state = 2'd2; step(2);
    pin[0] = 1; step(3); chk("R4 rise bypass early", 32'(wake_req), 0);
    step(1); chk("R4 rise bypass", 32'(wake_req), 1);
    pin[0] = 0; step(18); chk("R4 fall filtered early", 32'(wake_req), 1);
    step(1); chk("R4 fall filtered", 32'(wake_req), 0);

    // R5 combine, random levels
    quiet();
    for (int i = 0; i < 40; i++) begin
      logic [1:0] low_act, lvl, en;
      bit am;
      pwr_state = 2'd0;
      low_act = 2'($urandom % 4); lvl = 2'($urandom % 4);
      en = 2'($urandom % 4); am = 1'($urandom % 2);
      act_type = {1'b0, low_act[1], 1'b0, low_act[0]};
      wake_en = {2'b00, en}; comb_and = am; pin = lvl;
      step(5); pwr_state = 2'd2; step(1);
      chk($sformatf("R5 combine and=%0d en=%0b lvl=%0b", am, en, lvl),
          32'(wake_req), 32'(exp_pins(en, lvl, low_act, am)));
    end
    // R5 AND with a disabled pin
    quiet(); act_type = 4'b0000; comb_and = 1; wake_en = 4'b0001; pin = 2'b11; step(5);
    pwr_state = 2'd2; step(2); chk("R5 and disabled pin", 32'(wake_req), 0);

    // R6 mask and R9 sticky/clear
    quiet(); wake_en = 4'b0000; pwr_state = 2'd2; rtc_wake = 1; step(3);
    chk("R6 rtc masked req", 32'(wake_req), 0);
    chk("R6 rtc masked src", 32'(wake_src), 0);
    wake_en = 4'b0100; step(1); chk("R6 rtc enabled", 32'(wake_req), 1);
    chk("R9 rtc source", 32'(wake_src), 32'h2);
    rtc_wake = 0; step(1); chk("R6 rtc drop", 32'(wake_req), 0);
    step(8); chk("R9 sticky", 32'(wake_src), 32'h2);
    wake_en = 4'b1000; btn_wake = 1; step(1);
    chk("R6 button enabled", 32'(wake_req), 1);
    btn_wake = 0; chk("R9 button source", 32'(wake_src), 32'h3);
    src_clr = 1; step(1); src_clr = 0; chk("R9 clear", 32'(wake_src), 0);

    // R7 non-OFF states ignore
    quiet(); wake_en = 4'b0001; act_type = 4'b0000; pin[0] = 1; pwr_state = 2'd0; step(10);
    chk("R7 run ignored", 32'(wake_req), 0);
    pwr_state = 2'd3; step(10); chk("R7 reserved ignored", 32'(wake_req), 0);
    chk("R7 no source", 32'(wake_src), 0);
    pwr_state = 2'd2; step(1); chk("R7 off delivers", 32'(wake_req), 1);

    // R8 RTC discard and latch
    quiet(); wake_en = 4'b1000; pwr_state = 2'd1; rtc_latch = 0;
    btn_wake = 1; step(1); btn_wake = 0; step(3);
    chk("R8 rtc no req", 32'(wake_req), 0);
    pwr_state = 2'd2; step(3);
    chk("R8 discarded req", 32'(wake_req), 0);
    chk("R8 discarded src", 32'(wake_src), 0);
    pwr_state = 2'd1; rtc_latch = 1; btn_wake = 1; step(1); btn_wake = 0; step(3);
    chk("R8 latched held", 32'(wake_req), 0);
    chk("R8 latched no src yet", 32'(wake_src), 0);
    pwr_state = 2'd2; step(1);
    chk("R8 latched delivered", 32'(wake_req), 1);
    chk("R8 latched src", 32'(wake_src), 32'h1);
    step(1); chk("R8 delivered once", 32'(wake_req), 0);

    // R9 hardware reset bit, set beats clear
    quiet(); hw_evt = 1; step(1); hw_evt = 0;
    chk("R9 hw bit in run", 32'(wake_src), 32'h8);
    pwr_state = 2'd2; wake_en = 4'b0100; rtc_wake = 1; step(1); rtc_wake = 0;
    chk("R9 accumulate", 32'(wake_src), 32'hA);
    src_clr = 1; hw_evt = 1; step(1); src_clr = 0; hw_evt = 0;
    chk("R9 set wins clear", 32'(wake_src), 32'h8);

    // R10 glitch bypass, L = 56
    quiet(); act_type = 4'b0000; flt_en = 2'b11; flt_edge = 4'b1010;
    flt_intv = 8'h33; flt_cnt = 8'h55; glitch_sel = 2'b01; wake_en = 4'b0001;
    pwr_state = 2'd2; step(2);
    pin[0] = 1; step(4); chk("R10 pin0 bypassed", 32'(wake_req), 1);
    quiet(); act_type = 4'b0000; flt_en = 2'b11; flt_edge = 4'b1010;
    flt_intv = 8'h33; flt_cnt = 8'h55; glitch_sel = 2'b10; wake_en = 4'b0010;
    pwr_state = 2'd2; step(2);
    pin[1] = 1; step(58); chk("R10 pin1 still filtered", 32'(wake_req), 0);
    step(1); chk("R10 pin1 accepted", 32'(wake_req), 1);
    quiet(); act_type = 4'b0000; flt_en = 2'b01; flt_edge = 4'b0010;
    flt_intv = 8'h03; flt_cnt = 8'h05; glitch_sel = 2'b00; wake_en = 4'b0001;
    pwr_state = 2'd2; step(2);
    pin[0] = 1; step(4); chk("R10 filter restored early", 32'(wake_req), 0);
    step(55); chk("R10 filter restored", 32'(wake_req), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule